// File: doc/BRIEF.md
# Queue Fetch Sequencer with Wrap-Split DMA

The block moves pending packets from a circular queue in host memory into a local packet ring. Each packet is 64 bytes. When the host write index is ahead of the read index the block owns, it asks the local ring allocator for as many slots as there are pending packets. The allocator answers in the same cycle with a grant and the local write position after that grant. The block then advances its read index by the grant and emits a series of DMA read commands. It splits the series so that no single transfer crosses the end of the host queue or the end of the local ring.

Completions are counted against the packets of the series. When every packet has arrived, the block pulses a processing request and returns to idle. If the allocator grants nothing, or if the grant is used up while host packets remain, the block raises a stall flag. After that it makes no new request until a local slot retires. A retirement seen while a series is still running is remembered and acted on once the series ends.

Indices are free-running counters of `IDXW` bits. The host queue depth is `2**q_size_lg2_i` packets. The local ring depth is the parameter `LDEPTH`, a power of two.

Top module: `qfetch_seq`

## Requirements
- R1: During reset and right after it, the read index is 0 and `alloc_req_o`, `dma_valid_o`, `stall_o`, `busy_o` and `proc_req_o` are all low.
- R2: No allocation request is made while `q_wr_idx_i` equals the read index.
- R3: An allocation request is made only while idle. It carries the pending count (write index minus read index, modulo 2**IDXW). It is never made while `busy_o` is high.
- R4: The read index advances by the granted count, not the requested count, at the clock edge of the request. At all other times it holds.
- R5: A zero grant sets `stall_o`. While stalled, no request is made until `slot_retire_i` pulses. A nonzero grant clears `stall_o`.
- R6: `dma_valid_o` is high exactly while a series has commands left to issue. Each command's `dma_cnt_o` is the minimum of four limits: host slots before the queue end, local slots before the ring end, host packets remaining, and grant remaining.
- R7: The first command's `dma_slot_o` is `alloc_wr_pos_i` minus the grant, modulo LDEPTH. Each accepted command advances the local slot modulo LDEPTH and the host position modulo the host depth. No command crosses the end of the local ring.
- R8: `dma_addr_o` = `q_base_i` + (host position × 64) and `dma_len_o` = `dma_cnt_o` × 64.
- R9: If the grant runs out while host packets remain, `stall_o` rises at the edge that accepts the last command. A `slot_retire_i` pulse, including one that arrives while busy, triggers a new attempt.
- R10: `dma_done_i` subtracts `dma_done_cnt_i` from the series' outstanding count. At the edge where the count reaches zero, `busy_o` falls and `proc_req_o` is high for exactly one cycle.
- R11: While `dma_valid_o` is high and `dma_ready_i` is low, the command fields hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q_base_i | input | AW | Host queue base byte address |
| q_size_lg2_i | input | LG2W | Log2 of host queue depth in packets |
| q_wr_idx_i | input | IDXW | Host write index |
| q_rd_idx_o | output | IDXW | Host read index owned by the block |
| alloc_req_o | output | 1 | Local slot request |
| alloc_num_o | output | IDXW | Slots requested |
| alloc_gnt_i | input | clog2(LDEPTH+1) | Slots granted in the same cycle |
| alloc_wr_pos_i | input | clog2(LDEPTH) | Local write position after the grant |
| dma_valid_o | output | 1 | DMA command valid |
| dma_ready_i | input | 1 | DMA command accepted |
| dma_addr_o | output | AW | Host source byte address |
| dma_len_o | output | clog2(LDEPTH+1)+6 | Transfer length in bytes |
| dma_slot_o | output | clog2(LDEPTH) | Local start slot |
| dma_cnt_o | output | clog2(LDEPTH+1) | Packets in the command |
| dma_done_i | input | 1 | A command completed |
| dma_done_cnt_i | input | clog2(LDEPTH+1) | Packets in the completed command |
| slot_retire_i | input | 1 | A local slot retired |
| stall_o | output | 1 | Stalled on local buffer space |
| busy_o | output | 1 | A fetch series is in progress |
| proc_req_o | output | 1 | One-cycle request to process fetched packets |

## Verification
The hardest case to reach from the ports is a retirement that lands while a series started by a partial grant is still in flight. That pulse must be remembered, so that the idle, stalled block retries at once when the series ends. The bench reaches it as follows: it lets its own allocator model drain, stops automatic retirements, and pushes more packets than the local ring holds. It then injects a single retire pulse while the commands are still being issued. A second sequence makes the allocator refuse outright. This covers the zero-grant stall and checks that nothing happens until a retirement arrives. Random ready and completion timing, across two host depths and a host read position near the queue end, exercises every limit in the chunk minimum.

// File: rtl/qf_pkg.sv
package qf_pkg;
  typedef enum logic [1:0] {QF_IDLE, QF_ISSUE, QF_WAIT} qf_state_e;
  localparam int unsigned PKT_SHIFT = 6;
endpackage

// File: rtl/qf_chunk_calc.sv
module qf_chunk_calc #(
  parameter int unsigned IDXW   = 16,
  parameter int unsigned LDEPTH = 16,
  parameter int unsigned LG2W   = 4,
  localparam int unsigned LW    = $clog2(LDEPTH),
  localparam int unsigned CW    = $clog2(LDEPTH + 1)
) (
  input  logic [IDXW-1:0] h_pos_i,
  input  logic [LG2W-1:0] h_lg2_i,
  input  logic [LW-1:0]   l_pos_i,
  input  logic [IDXW-1:0] h_left_i,
  input  logic [CW-1:0]   g_left_i,
  output logic [CW-1:0]   cnt_o
);
  localparam int unsigned NLIM = 4;
  logic [IDXW:0] lim [NLIM];
  logic [IDXW:0] best [NLIM];

  assign lim[0] = ((IDXW+1)'(1) << h_lg2_i) - {1'b0, h_pos_i};
  assign lim[1] = (IDXW+1)'(LDEPTH) - (IDXW+1)'(l_pos_i);
  assign lim[2] = {1'b0, h_left_i};
  assign lim[3] = (IDXW+1)'(g_left_i);

  assign best[0] = lim[0];
  for (genvar i = 1; i < NLIM; i++) begin : g_min
    assign best[i] = (lim[i] < best[i-1]) ? lim[i] : best[i-1];
  end

  assign cnt_o = CW'(best[NLIM-1]);
endmodule

// File: rtl/qf_series_ctr.sv
module qf_series_ctr #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  input  logic [CW-1:0] dec_cnt_i,
  output logic [CW-1:0] left_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_o <= '0;
    else if (load_i) left_o <= load_val_i;
    else if (dec_i)  left_o <= left_o - dec_cnt_i;
  end
endmodule

// File: rtl/qfetch_seq.sv
module qfetch_seq
  import qf_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned IDXW   = 16,
  parameter int unsigned LDEPTH = 16,
  parameter int unsigned LG2W   = 4,
  localparam int unsigned LW    = $clog2(LDEPTH),
  localparam int unsigned CW    = $clog2(LDEPTH + 1),
  localparam int unsigned BW    = CW + PKT_SHIFT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   q_base_i,
  input  logic [LG2W-1:0] q_size_lg2_i,
  input  logic [IDXW-1:0] q_wr_idx_i,
  output logic [IDXW-1:0] q_rd_idx_o,
  output logic            alloc_req_o,
  output logic [IDXW-1:0] alloc_num_o,
  input  logic [CW-1:0]   alloc_gnt_i,
  input  logic [LW-1:0]   alloc_wr_pos_i,
  output logic            dma_valid_o,
  input  logic            dma_ready_i,
  output logic [AW-1:0]   dma_addr_o,
  output logic [BW-1:0]   dma_len_o,
  output logic [LW-1:0]   dma_slot_o,
  output logic [CW-1:0]   dma_cnt_o,
  input  logic            dma_done_i,
  input  logic [CW-1:0]   dma_done_cnt_i,
  input  logic            slot_retire_i,
  output logic            stall_o,
  output logic            busy_o,
  output logic            proc_req_o
);
  qf_state_e       state_q;
  logic [IDXW-1:0] rd_q, hpos_q, h_left_q, pending, h_mask;
  logic [LW-1:0]   lpos_q;
  logic [CW-1:0]   g_left_q, chunk_cnt, ser_left;
  logic            stall_q, retry_q, proc_q, attempt, gnt_nz;

  assign pending = q_wr_idx_i - rd_q;
  assign h_mask  = (IDXW'(1) << q_size_lg2_i) - IDXW'(1);
  assign gnt_nz  = (alloc_gnt_i != '0);
  // retry only after a retirement once stalled
  assign attempt = (state_q == QF_IDLE) && (pending != '0) &&
                   (!stall_q || retry_q || slot_retire_i);

  qf_chunk_calc #(.IDXW(IDXW), .LDEPTH(LDEPTH), .LG2W(LG2W)) u_chunk (
    .h_pos_i (hpos_q),
    .h_lg2_i (q_size_lg2_i),
    .l_pos_i (lpos_q),
    .h_left_i(h_left_q),
    .g_left_i(g_left_q),
    .cnt_o   (chunk_cnt)
  );

  qf_series_ctr #(.CW(CW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (attempt && gnt_nz),
    .load_val_i(alloc_gnt_i),
    .dec_i     (dma_done_i),
    .dec_cnt_i (dma_done_cnt_i),
    .left_o    (ser_left)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= QF_IDLE;
      rd_q     <= '0;
      hpos_q   <= '0;
      lpos_q   <= '0;
      g_left_q <= '0;
      h_left_q <= '0;
      stall_q  <= 1'b0;
      retry_q  <= 1'b0;
      proc_q   <= 1'b0;
    end else begin
      proc_q <= 1'b0;
      if (attempt)            retry_q <= 1'b0;
      else if (slot_retire_i) retry_q <= 1'b1;
      unique case (state_q)
        QF_IDLE: begin
          if (attempt) begin
            if (!gnt_nz) begin
              stall_q <= 1'b1;
            end else begin
              stall_q  <= 1'b0;
              rd_q     <= rd_q + IDXW'(alloc_gnt_i);
              hpos_q   <= rd_q & h_mask;
              lpos_q   <= alloc_wr_pos_i - LW'(alloc_gnt_i);
              g_left_q <= alloc_gnt_i;
              h_left_q <= pending;
              state_q  <= QF_ISSUE;
            end
          end
        end
        QF_ISSUE: begin
          if (dma_ready_i) begin
            hpos_q   <= (hpos_q + IDXW'(chunk_cnt)) & h_mask;
            lpos_q   <= lpos_q + LW'(chunk_cnt);
            g_left_q <= g_left_q - chunk_cnt;
            h_left_q <= h_left_q - IDXW'(chunk_cnt);
            if (g_left_q == chunk_cnt) begin
              state_q <= QF_WAIT;
              if (h_left_q != IDXW'(chunk_cnt)) stall_q <= 1'b1;
            end
          end
        end
        QF_WAIT: begin
          if (ser_left == '0 || (dma_done_i && ser_left == dma_done_cnt_i)) begin
            state_q <= QF_IDLE;
            proc_q  <= 1'b1;
          end
        end
        default: state_q <= QF_IDLE;
      endcase
    end
  end

  assign q_rd_idx_o  = rd_q;
  assign alloc_req_o = attempt;
  assign alloc_num_o = pending;
  assign dma_valid_o = (state_q == QF_ISSUE);
  assign dma_addr_o  = q_base_i + (AW'(hpos_q) << PKT_SHIFT);
  assign dma_len_o   = BW'(chunk_cnt) << PKT_SHIFT;
  assign dma_slot_o  = lpos_q;
  assign dma_cnt_o   = chunk_cnt;
  assign stall_o     = stall_q;
  assign busy_o      = (state_q != QF_IDLE);
  assign proc_req_o  = proc_q;
endmodule

// File: rtl/qfetch_seq_chk.sv
module qfetch_seq_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned IDXW   = 16,
  parameter int unsigned LDEPTH = 16,
  localparam int unsigned LW    = $clog2(LDEPTH),
  localparam int unsigned CW    = $clog2(LDEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IDXW-1:0] q_wr_idx_i,
  input logic [IDXW-1:0] q_rd_idx_o,
  input logic            alloc_req_o,
  input logic [CW-1:0]   alloc_gnt_i,
  input logic            dma_valid_o,
  input logic            dma_ready_i,
  input logic [AW-1:0]   dma_addr_o,
  input logic [LW-1:0]   dma_slot_o,
  input logic [CW-1:0]   dma_cnt_o,
  input logic            stall_o,
  input logic            busy_o,
  input logic            proc_req_o
);
  AST_EMPTY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wr_idx_i == q_rd_idx_o) |-> !alloc_req_o); // R2
  AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !alloc_req_o); // R3
  AST_RD_BY_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_o |=> (q_rd_idx_o == $past(q_rd_idx_o) + IDXW'($past(alloc_gnt_i)))); // R4
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_req_o |=> $stable(q_rd_idx_o)); // R4
  AST_ZERO_GNT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_o && alloc_gnt_i == '0) |=> stall_o); // R5
  AST_CHUNK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_o |-> (dma_cnt_o != '0)); // R6
  AST_NO_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_o |-> (int'(dma_slot_o) + int'(dma_cnt_o) <= int'(LDEPTH))); // R7
  AST_PROC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_req_o |=> !proc_req_o); // R10
  AST_PROC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_req_o |-> !busy_o); // R10
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_valid_o && !dma_ready_i) |=>
      (dma_valid_o && $stable(dma_addr_o) && $stable(dma_cnt_o) && $stable(dma_slot_o))); // R11
endmodule

bind qfetch_seq qfetch_seq_chk #(.AW(AW), .IDXW(IDXW), .LDEPTH(LDEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .q_wr_idx_i (q_wr_idx_i),
  .q_rd_idx_o (q_rd_idx_o),
  .alloc_req_o(alloc_req_o),
  .alloc_gnt_i(alloc_gnt_i),
  .dma_valid_o(dma_valid_o),
  .dma_ready_i(dma_ready_i),
  .dma_addr_o (dma_addr_o),
  .dma_slot_o (dma_slot_o),
  .dma_cnt_o  (dma_cnt_o),
  .stall_o    (stall_o),
  .busy_o     (busy_o),
  .proc_req_o (proc_req_o)
);

// File: tb/tb_qfetch_seq.sv
`timescale 1ns/1ps
module tb_qfetch_seq;
  localparam int AW = 32, IDXW = 16, LDEPTH = 16, LG2W = 4;
  localparam int LW = $clog2(LDEPTH), CW = $clog2(LDEPTH + 1), BW = CW + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0]   q_base = '0;
  logic [LG2W-1:0] q_lg2 = 4'd3;
  logic [IDXW-1:0] q_wr = '0, q_rd;
  logic            alloc_req;
  logic [IDXW-1:0] alloc_num;
  logic [CW-1:0]   alloc_gnt;
  logic [LW-1:0]   alloc_wr_pos;
  logic            dma_valid, dma_ready = 1'b0;
  logic [AW-1:0]   dma_addr;
  logic [BW-1:0]   dma_len;
  logic [LW-1:0]   dma_slot;
  logic [CW-1:0]   dma_cnt;
  logic            dma_done = 1'b0;
  logic [CW-1:0]   dma_done_cnt = '0;
  logic            slot_retire = 1'b0;
  logic            stall, busy, proc_req;

  qfetch_seq #(.AW(AW), .IDXW(IDXW), .LDEPTH(LDEPTH), .LG2W(LG2W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .q_base_i(q_base), .q_size_lg2_i(q_lg2),
    .q_wr_idx_i(q_wr), .q_rd_idx_o(q_rd), .alloc_req_o(alloc_req), .alloc_num_o(alloc_num),
    .alloc_gnt_i(alloc_gnt), .alloc_wr_pos_i(alloc_wr_pos), .dma_valid_o(dma_valid),
    .dma_ready_i(dma_ready), .dma_addr_o(dma_addr), .dma_len_o(dma_len), .dma_slot_o(dma_slot),
    .dma_cnt_o(dma_cnt), .dma_done_i(dma_done), .dma_done_cnt_i(dma_done_cnt),
    .slot_retire_i(slot_retire), .stall_o(stall), .busy_o(busy), .proc_req_o(proc_req));

  // knobs set by the main sequence
  int  wr_knob = 0, lg2_knob = 3, base_knob = 0;
  int  ready_pct = 100, done_pct = 100;
  bit  retire_en = 1'b1, gnt_block = 1'b0, force_retire = 1'b0;
  bit  run = 1'b0;

  // reference model state
  int  l_free = LDEPTH, l_used = 0, l_wr = 0;
  int  m_rd = 0, m_out = 0;
  bit  m_stall = 0, m_busy = 0, m_retry = 0, m_stall_after = 0, exp_proc = 0;
  int  eq_addr[$], eq_cnt[$], eq_slot[$], inflight[$];
  bit  ev_alloc = 0, ev_hs = 0, ev_done = 0, ev_retire = 0;
  int  ev_gnt = 0, ev_pend = 0, ev_hs_cnt = 0, ev_done_cnt = 0;
  int  n_checks = 0, n_fail = 0, cyc = 0;

  // allocator model: grants what is free, up to the request
  always_comb begin
    int g;
    g = gnt_block ? 0 : l_free;
    if (int'(alloc_num) < g) g = int'(alloc_num);
    alloc_gnt    = CW'(g);
    alloc_wr_pos = LW'((l_wr + g) % LDEPTH);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic build_series(input int rd, input int lpos, input int gnt, input int pend);
    int hd, hp, lp, lg, lh, c;
    hd = 1 << lg2_knob; hp = rd % hd; lp = lpos; lg = gnt; lh = pend;
    while (lg > 0) begin
      c = hd - hp;
      if (LDEPTH - lp < c) c = LDEPTH - lp;
      if (lh < c) c = lh;
      if (lg < c) c = lg;
      eq_addr.push_back(base_knob + hp * 64);
      eq_cnt.push_back(c);
      eq_slot.push_back(lp);
      hp = (hp + c) % hd; lp = (lp + c) % LDEPTH; lg -= c; lh -= c;
    end
  endtask

  function automatic int pend_now();
    return (int'(q_wr) - m_rd) & 16'hFFFF;
  endfunction

  always @(negedge clk) if (run) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
    // apply what happened at the last edge
    if (ev_retire) m_retry = 1;
    if (ev_alloc) begin
      m_retry = 0;
      if (ev_gnt == 0) m_stall = 1;
      else begin
        build_series(m_rd, l_wr, ev_gnt, ev_pend);
        m_rd = (m_rd + ev_gnt) & 16'hFFFF;
        l_wr = (l_wr + ev_gnt) % LDEPTH;
        l_free -= ev_gnt; l_used += ev_gnt;
        m_busy = 1; m_out = ev_gnt; m_stall = 0;
        m_stall_after = (ev_gnt < ev_pend);
      end
    end
    if (ev_hs) begin
      inflight.push_back(ev_hs_cnt);
      if (eq_cnt.size() == 0 && m_stall_after) m_stall = 1;
    end
    if (ev_done) begin
      m_out -= ev_done_cnt;
      if (m_out == 0) begin m_busy = 0; exp_proc = 1; end
    end
    ev_alloc = 0; ev_hs = 0; ev_done = 0; ev_retire = 0;

    // registered outputs
    chk(int'(q_rd) == m_rd, "R4 read index", int'(q_rd), m_rd);
    chk(stall == m_stall, "R5/R9 stall flag", stall, m_stall);
    chk(busy == m_busy, "R10 busy", busy, m_busy);
    chk(proc_req == exp_proc, "R10 proc pulse", proc_req, exp_proc);
    exp_proc = 0;

    // drive inputs
    q_wr  = IDXW'(wr_knob);
    q_lg2 = LG2W'(lg2_knob);
    q_base = AW'(base_knob);
    dma_ready = ($urandom_range(99) < ready_pct);
    dma_done = 1'b0;
    if (inflight.size() > 0 && $urandom_range(99) < done_pct) begin
      ev_done_cnt = inflight.pop_front();
      dma_done = 1'b1; dma_done_cnt = CW'(ev_done_cnt); ev_done = 1;
    end
    slot_retire = 1'b0;
    if (force_retire || (retire_en && l_used > 0 && $urandom_range(1) == 1)) begin
      slot_retire = 1'b1; ev_retire = 1; force_retire = 0;
      if (l_used > 0) begin l_used--; l_free++; end
    end

    #1;
    // combinational outputs for the coming edge
    begin
      bit exp_req;
      int p;
      p = pend_now();
      exp_req = !m_busy && p != 0 && (!m_stall || m_retry || slot_retire);
      if (p == 0) chk(!alloc_req, "R2 no request when empty", alloc_req, 0);
      else chk(alloc_req == exp_req, "R3/R5 request timing", alloc_req, exp_req);
      if (alloc_req) begin
        chk(int'(alloc_num) == p, "R3 request count", int'(alloc_num), p);
        ev_alloc = 1; ev_gnt = int'(alloc_gnt); ev_pend = p;
      end
      chk(dma_valid == (eq_cnt.size() > 0), "R6 command valid", dma_valid, eq_cnt.size() > 0);
      if (dma_valid && eq_cnt.size() > 0) begin
        chk(int'(dma_cnt) == eq_cnt[0], "R6 chunk length", int'(dma_cnt), eq_cnt[0]);
        chk(int'(dma_slot) == eq_slot[0], "R7 local slot", int'(dma_slot), eq_slot[0]);
        chk(dma_addr == AW'(eq_addr[0]), "R8 host address", int'(dma_addr), eq_addr[0]);
        chk(int'(dma_len) == eq_cnt[0] * 64, "R8 byte length", int'(dma_len), eq_cnt[0] * 64);
        if (dma_ready) begin
          ev_hs = 1; ev_hs_cnt = eq_cnt[0];
          void'(eq_cnt.pop_front()); void'(eq_slot.pop_front()); void'(eq_addr.pop_front());
        end
        // when not ready the same front entry is compared next cycle (R11)
      end
    end
  end

  task automatic wait_drained();
    do @(posedge clk);
    while (m_busy || ((wr_knob - m_rd) & 16'hFFFF) != 0 || int'(q_wr) != wr_knob || inflight.size() != 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic wait_local_empty();
    do @(posedge clk); while (l_used != 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(q_rd == '0, "R1 reset read index", int'(q_rd), 0);
    chk(!alloc_req && !dma_valid, "R1 reset request/valid", alloc_req | dma_valid, 0);
    chk(!stall && !busy && !proc_req, "R1 reset flags", stall | busy | proc_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_rd == '0 && !busy && !stall, "R1 after reset", int'(q_rd), 0);
    run = 1'b1;
    repeat (10) @(posedge clk);                 // R2: empty, idle

    lg2_knob = 3; base_knob = 32'h1000_0000;
    wr_knob = 5; wait_drained();                // simple series
    wr_knob = 13; wait_drained();               // host wrap at 8 (R6, R7)

    ready_pct = 50; done_pct = 40;
    for (int i = 0; i < 6; i++) begin
      wr_knob += 7; repeat (4) @(posedge clk);
    end
    wait_drained();

    lg2_knob = 5; base_knob = 32'h2000_0040;
    wr_knob += 40; wait_drained();              // partial grants, stall/retry (R9)

    // zero grant stall (R5)
    wait_local_empty();
    retire_en = 0; gnt_block = 1;
    wr_knob += 3;
    repeat (12) @(posedge clk);
    gnt_block = 0;
    repeat (12) @(posedge clk);                 // stalled: no request though space is free
    force_retire = 1;
    wait_drained();

    // retirement while busy is remembered (R9)
    retire_en = 1; wait_local_empty();
    retire_en = 0; ready_pct = 30; done_pct = 30;
    wr_knob += 20;
    do @(posedge clk); while (!m_busy);
    force_retire = 1;
    repeat (3) @(posedge clk);
    retire_en = 1; ready_pct = 70; done_pct = 60;
    wait_drained();

    for (int i = 0; i < 30; i++) begin
      wr_knob += 1 + (i * 5) % 23; repeat (6) @(posedge clk);
    end
    wait_drained();

    run = 1'b0;
    @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule